// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog for a 32-bit register bus. Software programs a 12-bit reload value and a clock divider, then enables the watchdog. A free-running prescaler turns the bus clock into slow ticks, and a down-counter loaded with the scaled reload value counts those ticks. If software does not service the watchdog before the counter reaches zero, the block sets a sticky timeout flag. It can then drive a level interrupt, a fixed-length reset pulse, or both.

Writes to the configuration registers are guarded by magic values in their upper bits, so a runaway program that scribbles over the address range is unlikely to reconfigure the watchdog. Servicing requires writing one exact word to a separate register. Reads return the stored fields with the key bits as zero and are returned one cycle after the read strobe.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, irq_o and rst_o are low, the mode word reads 0x00000000, the control word reads 0x00003FFF (reload field all ones, divider code 3) and the status word reads 0.
- R2: A write to offset 0x0 whose bits 23:12 equal 0xABC stores: bit 0 watchdog enable, bit 1 reset-output enable, bit 2 interrupt enable, bits 5:4 pulse-length code. A read of offset 0x0 returns those fields in the same positions with every other bit zero.
- R3: A write to offset 0x0 or 0x4 without the matching key is ignored and leaves the stored fields unchanged.
- R4: A write to offset 0x4 whose bits 23:14 equal 0x248 (that is, the word carries 0x0092_0000) stores the reload field from bits 13:2 and the divider code from bits 1:0. A read returns them in those positions.
- R5: Divider codes 0, 1, 2 and 3 give one tick every 2^PS_SH0 to 2^PS_SH3 bus cycles. The defaults are 8, 64, 512 and 4096. Once the watchdog is enabled and serviced, the timeout flag sets after reload × 2^RLD_SH ticks.
- R6: Writing exactly 0x00001999 to offset 0x8 reloads the counter, restarts the prescaler and clears the timeout flag. Any other value written there is ignored.
- R7: Status bit 0 is the timeout flag. It stays set until a service write. irq_o, registered, equals the flag ANDed with the interrupt enable.
- R8: When the flag sets with the reset-output enable on, rst_o goes high once for 2, 4, 8 or 16 cycles for pulse-length codes 0 to 3.
- R9: While the enable bit is clear, the counter holds its reload value and the flag cannot set. A keyed mode write that clears the enable bit stops the watchdog.
- R10: A read of offset 0x8 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset, bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Level timeout interrupt |
| rst_o | output | 1 | Timeout reset pulse |

## Verification
The bench builds the block with RLD_SH=2 and divider shifts 1, 2, 3 and 4. With these values a reload field of 3 gives 12 ticks, and every divider code times out within a few hundred cycles. Time-outs on all four divider codes and all four pulse lengths can therefore be measured to the cycle window. The same stretch of logic would take millions of cycles at the default scaling.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [11:0] MODE_KEY    = 12'hABC;
  localparam logic [9:0]  CTRL_KEY    = 10'h248;
  localparam logic [31:0] SERVICE_VAL = 32'h0000_1999;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       en;
  } mode_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CRV_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              flag,
  output mode_t             mode_q,
  output logic [CRV_W-1:0]  crv_q,
  output logic [1:0]        ps_q,
  output logic              service,
  output logic [31:0]       bus_rdata
);
  logic [1:0] word;
  logic       wr, rd;
  assign word = bus_addr[3:2];
  assign wr   = bus_en && bus_we;
  assign rd   = bus_en && !bus_we;

  assign service = wr && (word == 2'd2) && (bus_wdata == SERVICE_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      crv_q  <= '1;
      ps_q   <= 2'd3;
    end else if (wr) begin
      if (word == 2'd0 && bus_wdata[23:12] == MODE_KEY) begin
        mode_q.en     <= bus_wdata[0];
        mode_q.rst_en <= bus_wdata[1];
        mode_q.irq_en <= bus_wdata[2];
        mode_q.plen   <= bus_wdata[5:4];
      end
      if (word == 2'd1 && bus_wdata[23:14] == CTRL_KEY) begin
        crv_q <= bus_wdata[CRV_W+1:2];
        ps_q  <= bus_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (word)
        2'd0:    bus_rdata <= {26'd0, mode_q.plen, 1'b0, mode_q.irq_en,
                               mode_q.rst_en, mode_q.en};
        2'd1:    bus_rdata <= 32'(({CRV_W'(0), 2'b00} | {crv_q, 2'b00}) | 32'(ps_q));
        2'd3:    bus_rdata <= {31'd0, flag};
        default: bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PS_SH0 = 3,
  parameter int PS_SH1 = 6,
  parameter int PS_SH2 = 9,
  parameter int PS_SH3 = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int M01 = (PS_SH0 > PS_SH1) ? PS_SH0 : PS_SH1;
  localparam int M23 = (PS_SH2 > PS_SH3) ? PS_SH2 : PS_SH3;
  localparam int MX  = (M01 > M23) ? M01 : M23;
  localparam int PW  = (MX < 1) ? 1 : MX;

  logic [PW-1:0] cnt, lim;

  always_comb begin
    case (sel)
      2'd0:    lim = PW'((64'd1 << PS_SH0) - 64'd1);
      2'd1:    lim = PW'((64'd1 << PS_SH1) - 64'd1);
      2'd2:    lim = PW'((64'd1 << PS_SH2) - 64'd1);
      default: lim = PW'((64'd1 << PS_SH3) - 64'd1);
    endcase
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (tick)          cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CRV_W  = 12,
  parameter int RLD_SH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             service,
  input  logic             tick,
  input  logic [CRV_W-1:0] crv,
  output logic             flag,
  output logic             expire
);
  localparam int CW = CRV_W + RLD_SH;

  logic [CW-1:0] cnt, load;
  assign load   = CW'(crv) << RLD_SH;
  assign expire = en && !service && !flag && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= load;
    else if (!en || service)        cnt <= load;
    else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (service) flag <= 1'b0;
    else if (expire)  flag <= 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [PL_W-1:0] code,
  output logic            pulse
);
  localparam int CNT_W = (1 << PL_W) + 1;

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      pulse <= 1'b0;
    end else if (fire) begin
      left  <= (CNT_W'(2) << code) - 1'b1;
      pulse <= 1'b1;
    end else if (left != '0) begin
      left  <= left - 1'b1;
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CRV_W  = 12,
  parameter int RLD_SH = 12,
  parameter int PS_SH0 = 3,
  parameter int PS_SH1 = 6,
  parameter int PS_SH2 = 9,
  parameter int PS_SH3 = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              rst_o
);
  mode_t            mode_q;
  logic [CRV_W-1:0] crv_q;
  logic [1:0]       ps_q;
  logic             service, tick, flag, expire;
  logic             wd_en, wd_irq_en;

  assign wd_en     = mode_q.en;
  assign wd_irq_en = mode_q.irq_en;

  wdt_regs #(.ADDR_W(ADDR_W), .CRV_W(CRV_W)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag(flag),
    .mode_q(mode_q), .crv_q(crv_q), .ps_q(ps_q), .service(service),
    .bus_rdata(bus_rdata)
  );

  wdt_prescale #(.PS_SH0(PS_SH0), .PS_SH1(PS_SH1), .PS_SH2(PS_SH2),
                 .PS_SH3(PS_SH3)) u_pre (
    .clk(clk), .rst(rst), .run(wd_en), .clr(service), .sel(ps_q),
    .tick(tick)
  );

  wdt_counter #(.CRV_W(CRV_W), .RLD_SH(RLD_SH)) u_cnt (
    .clk(clk), .rst(rst), .en(wd_en), .service(service), .tick(tick),
    .crv(crv_q), .flag(flag), .expire(expire)
  );

  wdt_pulse #(.PL_W(2)) u_pulse (
    .clk(clk), .rst(rst), .fire(expire && mode_q.rst_en),
    .code(mode_q.plen), .pulse(rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= flag && wd_irq_en;
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              wd_en,
  input logic              wd_irq_en,
  input logic              flag,
  input logic              irq_o,
  input logic              rst_o
);
  logic [5:0] hi_run;
  logic       svc;
  assign svc = bus_en && bus_we && bus_addr[3:2] == 2'd2 && bus_wdata == 32'h1999;

  always_ff @(posedge clk) begin
    if (rst)        hi_run <= '0;
    else if (rst_o) hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  AST_BAD_MODE_KEY: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr[3:2] == 2'd0 && bus_wdata[23:12] != 12'hABC)
      |=> ($stable(wd_en) && $stable(wd_irq_en))); // R3
  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    svc |=> !flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !svc) |=> flag); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(flag)); // R7
  AST_IDLE_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (!wd_en && !flag) |=> !flag); // R9
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    rst_o |-> (hi_run < 6'd16)); // R8
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wd_en(wd_en),
  .wd_irq_en(wd_irq_en), .flag(flag), .irq_o(irq_o), .rst_o(rst_o)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  localparam int RSH = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, rst_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  keyed_watchdog #(.ADDR_W(4), .CRV_W(12), .RLD_SH(RSH), .PS_SH0(1),
                   .PS_SH1(2), .PS_SH2(3), .PS_SH3(4)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_o(rst_o)
  );

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mode_w(bit en, bit re, bit ie, logic [1:0] pl);
    return 32'h00AB_C000 | {26'd0, pl, 1'b0, ie, re, en};
  endfunction

  function automatic logic [31:0] ctrl_w(logic [11:0] crv, logic [1:0] ps);
    return 32'h0092_0000 | {18'd0, crv, ps};
  endfunction

  task automatic wait_irq(int lim, output int n);
    n = 0;
    while (!irq_o && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", irq_o, 0);
    chk("R1 rst", rst_o, 0);
    rd(4'h0, d); chk("R1 mode", d, 0);
    rd(4'h4, d); chk("R1 ctrl", d, 32'h3FFF);
    rd(4'hC, d); chk("R1 status", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'h0, mode_w(0, 1, 1, 2'd2) | 32'h40);
    rd(4'h0, d); chk("R2 mode fields", d, 32'h26);
    wr(4'h4, ctrl_w(12'hA5C, 2'd1));
    rd(4'h4, d); chk("R4 ctrl fields", d, {18'd0, 12'hA5C, 2'd1});
    wr(4'h0, 32'h00AB_D007);
    rd(4'h0, d); chk("R3 mode bad key", d, 32'h26);
    wr(4'h4, 32'h0093_0002);
    rd(4'h4, d); chk("R3 ctrl bad key", d, {18'd0, 12'hA5C, 2'd1});
    rd(4'h8, d); chk("R10 service read", d, 0);
    wr(4'h0, mode_w(0, 0, 0, 0));
  endtask

  task automatic t_timeout(logic [1:0] ps);
    int n, per;
    logic [31:0] d;
    per = 12 * (2 << ps);
    wr(4'h4, ctrl_w(12'd3, ps));
    wr(4'h0, mode_w(1, 0, 1, 0));
    wr(4'h8, 32'h1999);
    wait_irq(per + 50, n);
    chk_rng("R5 timeout cycles", n, per, per + 4);
    rd(4'hC, d); chk("R7 status set", d, 1);
    repeat (20) @(negedge clk);
    chk("R7 sticky irq", irq_o, 1);
    wr(4'h8, 32'h1999);
    repeat (2) @(negedge clk);
    chk("R6 service clears irq", irq_o, 0);
    wr(4'h0, mode_w(0, 0, 1, 0));
  endtask

  task automatic t_service();
    int n;
    wr(4'h4, ctrl_w(12'd3, 2'd1));
    wr(4'h0, mode_w(1, 0, 1, 0));
    wr(4'h8, 32'h1999);
    repeat (30) @(negedge clk);
    wr(4'h8, 32'h1998);
    wait_irq(100, n);
    chk_rng("R6 wrong value ignored", n + 31, 48, 53);
    wr(4'h8, 32'h1999);
    repeat (30) @(negedge clk);
    wr(4'h8, 32'h1999);
    repeat (30) @(negedge clk);
    chk("R6 service delays timeout", irq_o, 0);
    wait_irq(100, n);
    chk_rng("R6 reload after service", n + 30, 48, 53);
    wr(4'h0, mode_w(1, 0, 0, 0));
    repeat (2) @(negedge clk);
    chk("R7 irq masked", irq_o, 0);
    wr(4'h8, 32'h1999);
    wr(4'h0, mode_w(0, 0, 1, 0));
  endtask

  task automatic t_pulse(logic [1:0] pl);
    int n, w;
    wr(4'h4, ctrl_w(12'd1, 2'd0));
    wr(4'h0, mode_w(1, 1, 0, pl));
    wr(4'h8, 32'h1999);
    n = 0;
    while (!rst_o && n < 100) begin @(negedge clk); n++; end
    w = 0;
    while (rst_o && w < 40) begin @(negedge clk); w++; end
    chk("R8 pulse width", w, 2 << pl);
    repeat (30) @(negedge clk);
    chk("R8 single pulse", rst_o, 0);
    chk("R7 irq off when disabled", irq_o, 0);
    wr(4'h8, 32'h1999);
    wr(4'h0, mode_w(0, 0, 0, 0));
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(4'h4, ctrl_w(12'd3, 2'd1));
    wr(4'h0, mode_w(1, 0, 1, 0));
    wr(4'h8, 32'h1999);
    repeat (20) @(negedge clk);
    wr(4'h0, mode_w(0, 0, 1, 0));
    repeat (150) @(negedge clk);
    chk("R9 no irq while off", irq_o, 0);
    rd(4'hC, d); chk("R9 status while off", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    for (int p = 0; p < 4; p++) t_timeout(2'(p));
    t_service();
    for (int p = 0; p < 4; p++) t_pulse(2'(p));
    t_disable();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule